// File: doc/BRIEF.md
# Multi-Receiver Serial Receive Status Controller

This block keeps the receive-side status of a serial audio port that runs up to four receivers side by side, either with one word per frame (normal mode) or with several time slots per frame (network/TDM mode). Each time the shift logic finishes a word it pulses a transfer strobe. The block then loads the word of every enabled receiver into that receiver's data register and updates a small set of flags: data-full, overrun, even-slot full, odd-slot full and receive frame sync.

The CPU side talks to it through read strobes, one for the status word and one per data register. The full flags drop once every enabled receiver has been read. The overrun flag needs a stricter order: a status read that sees overrun set, then reads of all enabled data registers. Three interrupt requests come straight from the flags, and each one is gated by its own enable input.

Top module: `rxstat_ctrl`

## Requirements
- R1: While rst_n is low, all data registers, flags and interrupt requests are zero.
- R2: A transfer strobe with at least one receiver enabled loads each enabled receiver's word into its data register and sets stat_full on the next cycle. Disabled receivers keep their data. Receiver i's word is xfer_data[24*i+23:24*i].
- R3: stat_full stays set until each enabled receiver's data register has been read since its last load. Reads of disabled receivers, and missing reads from them, have no effect.
- R4: A transfer that arrives while stat_full is set raises stat_ovr, and the new word overwrites the data registers.
- R5: stat_ovr clears only in this order: a status read that sees it set, then reads of all enabled data registers. Data reads made before that status read do not count. A transfer that arrives before the sequence completes leaves stat_ovr set and cancels the sequence.
- R6: In network mode (net_mode=1), a transfer in an even slot (slot_idx bit 0 = 0, slot 0 included) sets stat_even and clears stat_odd, and an odd slot does the opposite. In normal mode a transfer leaves both flags at 0. Both flags clear under the same rule as stat_full.
- R7: stat_fsync is 0 when no receiver is enabled. With a receiver enabled, in normal mode it is 1, and in network mode it shows the fs_seen value captured with the last transfer.
- R8: irq_data = stat_full AND ie_data, irq_exc = stat_ovr AND ie_exc, irq_even = stat_even AND ie_even.
- R9: A transfer strobe while every receiver is disabled changes no data register and sets no flag.
- R10: When a data read and a transfer hit the same receiver in the same cycle, the transfer wins, and stat_full stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| net_mode | input | 1 | 1 selects network (multi-slot) mode |
| rx_en | input | 4 | Per-receiver enable |
| xfer_stb | input | 1 | Word-complete strobe from the shift registers |
| xfer_data | input | 96 | Shift-register words, receiver i in bits 24*i+23:24*i |
| slot_idx | input | 5 | Time slot of the word being transferred |
| fs_seen | input | 1 | Frame sync occurred during this word |
| sr_rd | input | 1 | CPU read of the status word |
| dr_rd | input | 4 | CPU read of each receiver's data register |
| ie_data | input | 1 | Data interrupt enable |
| ie_exc | input | 1 | Overrun interrupt enable |
| ie_even | input | 1 | Even-slot interrupt enable |
| rx_data | output | 96 | Receive data registers, same packing as xfer_data |
| stat_fsync | output | 1 | Receive frame sync flag |
| stat_ovr | output | 1 | Overrun flag |
| stat_full | output | 1 | Data-full flag |
| stat_even | output | 1 | Even-slot data flag |
| stat_odd | output | 1 | Odd-slot data flag |
| irq_data | output | 1 | Data interrupt request |
| irq_exc | output | 1 | Overrun interrupt request |
| irq_even | output | 1 | Even-slot interrupt request |

## Verification
The assertions check the single-step rules on every cycle. A transfer always sets full, a transfer onto full always raises overrun, and a transfer never drops a pending overrun. The even and odd flags are never both set. Data registers hold still when there is no enabled transfer, and frame sync is silent with no receiver enabled. The multi-cycle ordering needs the bench's scenarios: overrun surviving early data reads, a cancelled clear sequence, and full surviving partial reads. So does the exact data each receiver holds after mixed enables.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int NUM_RX    = 4;
  localparam int WORD_W    = 24;
  localparam int MAX_SLOTS = 32;
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
endpackage

// File: rtl/rxstat_lane.sv
module rxstat_lane #(
  parameter int WORD_W = rxstat_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              rd,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] data,
  output logic              pend_nx
);
  logic take;
  logic pend;

  always_comb begin
    take    = load & en;
    pend_nx = take ? 1'b1 : (rd ? 1'b0 : pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      pend <= 1'b0;
    end else begin
      if (take) data <= word;
      pend <= pend_nx;
    end
  end
endmodule

// File: rtl/rxstat_flags.sv
module rxstat_flags #(
  parameter int NUM_RX = rxstat_pkg::NUM_RX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_mode,
  input  logic              xfer_any,
  input  logic              slot_odd,
  input  logic              fs_seen,
  input  logic [NUM_RX-1:0] rx_en,
  input  logic [NUM_RX-1:0] pend_nx,
  output logic              full,
  output logic              even,
  output logic              odd,
  output logic              fsync
);
  logic full_nx, even_nx, odd_nx, rfs, rfs_nx, keep;

  always_comb begin
    keep    = |(pend_nx & rx_en);
    full_nx = full;
    even_nx = even;
    odd_nx  = odd;
    rfs_nx  = rfs;
    if (xfer_any) begin
      full_nx = 1'b1;
      even_nx = net_mode & ~slot_odd;
      odd_nx  = net_mode & slot_odd;
      rfs_nx  = fs_seen;
    end else if (!keep) begin
      full_nx = 1'b0;
      even_nx = 1'b0;
      odd_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      even <= 1'b0;
      odd  <= 1'b0;
      rfs  <= 1'b0;
    end else begin
      full <= full_nx;
      even <= even_nx;
      odd  <= odd_nx;
      rfs  <= rfs_nx;
    end
  end

  assign fsync = (|rx_en) & (net_mode ? rfs : 1'b1);
endmodule

// File: rtl/rxstat_ovr.sv
module rxstat_ovr #(
  parameter int NUM_RX = rxstat_pkg::NUM_RX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_any,
  input  logic              full,
  input  logic              sr_rd,
  input  logic [NUM_RX-1:0] dr_rd,
  input  logic [NUM_RX-1:0] rx_en,
  output logic              ovr
);
  logic              ovr_nx, armed, armed_nx;
  logic [NUM_RX-1:0] need, need_nx;

  always_comb begin
    ovr_nx   = ovr;
    armed_nx = armed;
    need_nx  = need;
    if (xfer_any) begin
      armed_nx = 1'b0;
      if (full) ovr_nx = 1'b1;
    end else if (ovr && sr_rd) begin
      armed_nx = 1'b1;
      need_nx  = rx_en;
    end else if (armed) begin
      need_nx = need & ~dr_rd;
      if ((need_nx & rx_en) == '0) begin
        ovr_nx   = 1'b0;
        armed_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr   <= 1'b0;
      armed <= 1'b0;
      need  <= '0;
    end else begin
      ovr   <= ovr_nx;
      armed <= armed_nx;
      need  <= need_nx;
    end
  end
endmodule

// File: rtl/rxstat_ctrl.sv
module rxstat_ctrl #(
  parameter int NUM_RX    = rxstat_pkg::NUM_RX,
  parameter int WORD_W    = rxstat_pkg::WORD_W,
  parameter int MAX_SLOTS = rxstat_pkg::MAX_SLOTS,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int BUS_W    = NUM_RX * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_mode,
  input  logic [NUM_RX-1:0] rx_en,
  input  logic              xfer_stb,
  input  logic [BUS_W-1:0]  xfer_data,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              fs_seen,
  input  logic              sr_rd,
  input  logic [NUM_RX-1:0] dr_rd,
  input  logic              ie_data,
  input  logic              ie_exc,
  input  logic              ie_even,
  output logic [BUS_W-1:0]  rx_data,
  output logic              stat_fsync,
  output logic              stat_ovr,
  output logic              stat_full,
  output logic              stat_even,
  output logic              stat_odd,
  output logic              irq_data,
  output logic              irq_exc,
  output logic              irq_even
);
  logic              xfer_any;
  logic [NUM_RX-1:0] pend_nx;

  assign xfer_any = xfer_stb & (|rx_en);

  for (genvar g = 0; g < NUM_RX; g++) begin : g_lane
    rxstat_lane #(.WORD_W(WORD_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (rx_en[g]),
      .load    (xfer_stb),
      .rd      (dr_rd[g]),
      .word    (xfer_data[g*WORD_W +: WORD_W]),
      .data    (rx_data[g*WORD_W +: WORD_W]),
      .pend_nx (pend_nx[g])
    );
  end

  rxstat_flags #(.NUM_RX(NUM_RX)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .net_mode (net_mode),
    .xfer_any (xfer_any),
    .slot_odd (slot_idx[0]),
    .fs_seen  (fs_seen),
    .rx_en    (rx_en),
    .pend_nx  (pend_nx),
    .full     (stat_full),
    .even     (stat_even),
    .odd      (stat_odd),
    .fsync    (stat_fsync)
  );

  rxstat_ovr #(.NUM_RX(NUM_RX)) u_ovr (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_any (xfer_any),
    .full     (stat_full),
    .sr_rd    (sr_rd),
    .dr_rd    (dr_rd),
    .rx_en    (rx_en),
    .ovr      (stat_ovr)
  );

  assign irq_data = stat_full & ie_data;
  assign irq_exc  = stat_ovr  & ie_exc;
  assign irq_even = stat_even & ie_even;
endmodule

// File: rtl/rxstat_sva.sv
module rxstat_sva #(
  parameter int NUM_RX = 4,
  parameter int BUS_W  = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_RX-1:0] rx_en,
  input logic              xfer_stb,
  input logic [NUM_RX-1:0] dr_rd,
  input logic              ie_data,
  input logic              ie_exc,
  input logic              ie_even,
  input logic [BUS_W-1:0]  rx_data,
  input logic              stat_fsync,
  input logic              stat_ovr,
  input logic              stat_full,
  input logic              stat_even,
  input logic              stat_odd,
  input logic              irq_data,
  input logic              irq_exc,
  input logic              irq_even
);
  p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && |rx_en) |=> stat_full);

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_full && dr_rd == '0 && $stable(rx_en)) |=> stat_full);

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && |rx_en && stat_full) |=> stat_ovr);

  p_ovr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ovr && xfer_stb && |rx_en) |=> stat_ovr);

  p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_even && stat_odd));

  p_fsync_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en == '0) |-> !stat_fsync);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_data && !ie_exc && !ie_even) |-> !(irq_data || irq_exc || irq_even));

  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_stb || rx_en == '0) |=> $stable(rx_data));
endmodule

bind rxstat_ctrl rxstat_sva #(.NUM_RX(NUM_RX), .BUS_W(BUS_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .xfer_stb   (xfer_stb),
  .dr_rd      (dr_rd),
  .ie_data    (ie_data),
  .ie_exc     (ie_exc),
  .ie_even    (ie_even),
  .rx_data    (rx_data),
  .stat_fsync (stat_fsync),
  .stat_ovr   (stat_ovr),
  .stat_full  (stat_full),
  .stat_even  (stat_even),
  .stat_odd   (stat_odd),
  .irq_data   (irq_data),
  .irq_exc    (irq_exc),
  .irq_even   (irq_even)
);

// File: tb/rxstat_ctrl_bench.sv
`timescale 1ns/1ps
module rxstat_ctrl_bench;
  localparam int N  = 4;
  localparam int W  = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic net_mode, xfer_stb, fs_seen, sr_rd, ie_data, ie_exc, ie_even;
  logic [N-1:0] rx_en, dr_rd;
  logic [N*W-1:0] xfer_data, rx_data;
  logic [4:0] slot_idx;
  logic stat_fsync, stat_ovr, stat_full, stat_even, stat_odd;
  logic irq_data, irq_exc, irq_even;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state derived from the requirements
  logic [W-1:0] m_data [N];
  logic [N-1:0] m_pend, m_need;
  logic m_full, m_even, m_odd, m_rfs, m_ovr, m_armed;

  always #10 clk = ~clk;

  rxstat_ctrl u_rxstat_ctrl (
    .clk(clk), .rst_n(rst_n), .net_mode(net_mode), .rx_en(rx_en),
    .xfer_stb(xfer_stb), .xfer_data(xfer_data), .slot_idx(slot_idx),
    .fs_seen(fs_seen), .sr_rd(sr_rd), .dr_rd(dr_rd), .ie_data(ie_data),
    .ie_exc(ie_exc), .ie_even(ie_even), .rx_data(rx_data),
    .stat_fsync(stat_fsync), .stat_ovr(stat_ovr), .stat_full(stat_full),
    .stat_even(stat_even), .stat_odd(stat_odd), .irq_data(irq_data),
    .irq_exc(irq_exc), .irq_even(irq_even));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane(int i);
    return rx_data[i*W +: W];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_data[i] = '0;
    m_pend = '0; m_need = '0;
    {m_full, m_even, m_odd, m_rfs, m_ovr, m_armed} = '0;
  endtask

  task automatic model_clock();
    logic x;
    logic [N-1:0] pn;
    x = xfer_stb && (rx_en != '0);
    for (int i = 0; i < N; i++)
      pn[i] = (xfer_stb && rx_en[i]) ? 1'b1 : (dr_rd[i] ? 1'b0 : m_pend[i]);
    if (x) begin
      if (m_full) m_ovr = 1'b1;
      m_armed = 1'b0;
    end else if (m_ovr && sr_rd) begin
      m_armed = 1'b1; m_need = rx_en;
    end else if (m_armed) begin
      m_need = m_need & ~dr_rd;
      if ((m_need & rx_en) == '0) begin m_ovr = 1'b0; m_armed = 1'b0; end
    end
    if (x) begin
      m_full = 1'b1;
      m_even = net_mode && !slot_idx[0];
      m_odd  = net_mode && slot_idx[0];
      m_rfs  = fs_seen;
    end else if ((pn & rx_en) == '0) begin
      m_full = 1'b0; m_even = 1'b0; m_odd = 1'b0;
    end
    for (int i = 0; i < N; i++)
      if (xfer_stb && rx_en[i]) m_data[i] = xfer_data[i*W +: W];
    m_pend = pn;
  endtask

  task automatic compare_all();
    logic efs;
    for (int i = 0; i < N; i++) chk("R2 data", lane(i), m_data[i]);
    chk("R3 full", stat_full, m_full);
    chk("R5 ovr", stat_ovr, m_ovr);
    chk("R6 even", stat_even, m_even);
    chk("R6 odd", stat_odd, m_odd);
    efs = (rx_en != '0) && (net_mode ? m_rfs : 1'b1);
    chk("R7 fsync", stat_fsync, efs);
    chk("R8 irq_data", irq_data, m_full & ie_data);
    chk("R8 irq_exc", irq_exc, m_ovr & ie_exc);
    chk("R8 irq_even", irq_even, m_even & ie_even);
  endtask

  task automatic step();
    @(posedge clk);
    model_clock();
    #1;
    compare_all();
  endtask

  task automatic idle();
    xfer_stb = 0; sr_rd = 0; dr_rd = '0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    rst_n = 0; net_mode = 0; rx_en = '0; xfer_stb = 0; xfer_data = '0;
    slot_idx = '0; fs_seen = 0; sr_rd = 0; dr_rd = '0;
    ie_data = 0; ie_exc = 0; ie_even = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 data", rx_data[31:0], 32'h0);
    chk("R1 flags", {stat_fsync, stat_ovr, stat_full, stat_even, stat_odd}, 0);
    chk("R1 irq", {irq_data, irq_exc, irq_even}, 0);
    rst_n = 1;

    // R2, R7 normal mode, R6 normal mode
    rx_en = 4'hF; xfer_stb = 1;
    xfer_data = {24'h333333, 24'h222222, 24'h111111, 24'h0A0A0A};
    step();
    chk("R2 lane0", lane(0), 24'h0A0A0A);
    chk("R2 full", stat_full, 1);
    chk("R7 normal fsync", stat_fsync, 1);
    chk("R6 normal even/odd", {stat_even, stat_odd}, 0);
    idle();
    // R3 partial reads keep full
    dr_rd = 4'b0111; step();
    chk("R3 partial", stat_full, 1);
    dr_rd = 4'b1000; step();
    chk("R3 all read", stat_full, 0);
    idle();

    // R2 disabled kept, R3 disabled ignored
    rx_en = 4'b0101; xfer_stb = 1; xfer_data = {4{24'h555555}};
    step();
    chk("R2 disabled lane1", lane(1), 24'h111111);
    chk("R2 enabled lane0", lane(0), 24'h555555);
    idle(); dr_rd = 4'b0101; step();
    chk("R3 disabled ignored", stat_full, 0);
    idle();

    // R6, R7 network mode
    rx_en = 4'hF; net_mode = 1; slot_idx = 5'd3; fs_seen = 0; xfer_stb = 1;
    step();
    chk("R6 odd slot", {stat_even, stat_odd}, 2'b01);
    chk("R7 net fsync0", stat_fsync, 0);
    slot_idx = 5'd0; fs_seen = 1; xfer_data = {4{24'hABCDEF}};
    step();
    chk("R4 overrun", stat_ovr, 1);
    chk("R4 overwrite", lane(2), 24'hABCDEF);
    chk("R6 slot0 even", {stat_even, stat_odd}, 2'b10);
    chk("R7 net fsync1", stat_fsync, 1);
    idle();

    // R5 ordering
    dr_rd = 4'hF; step();
    chk("R5 early reads", stat_ovr, 1);
    idle(); sr_rd = 1; step();
    idle(); dr_rd = 4'b0011; step();
    chk("R5 partial", stat_ovr, 1);
    idle(); xfer_stb = 1; slot_idx = 5'd2; step();
    idle(); dr_rd = 4'b1100; step();
    chk("R5 cancelled", stat_ovr, 1);
    idle(); sr_rd = 1; step();
    idle(); dr_rd = 4'hF; step();
    chk("R5 cleared", stat_ovr, 0);
    chk("R3 cleared", stat_full, 0);
    idle();

    // R8 interrupts
    ie_data = 1; ie_exc = 1; ie_even = 1; slot_idx = 5'd4;
    xfer_data = {4{24'h246810}}; xfer_stb = 1;
    step(); step();
    chk("R8 all irq", {irq_data, irq_exc, irq_even}, 3'b111);
    idle(); ie_data = 0; ie_exc = 0; ie_even = 0; step();
    chk("R8 gated", {irq_data, irq_exc, irq_even}, 3'b000);
    sr_rd = 1; step(); idle(); dr_rd = 4'hF; step(); idle();

    // R9 no receivers enabled
    rx_en = '0; xfer_stb = 1; xfer_data = {4{24'h777777}};
    step();
    chk("R9 data unchanged", lane(0), 24'h246810);
    chk("R9 no full", stat_full, 0);
    chk("R7 none enabled", stat_fsync, 0);
    idle();

    // R10 read and transfer together
    rx_en = 4'hF; xfer_stb = 1; step();
    dr_rd = 4'hF; step();
    chk("R10 transfer wins", stat_full, 1);
    idle(); step();
    chk("R10 pending kept", stat_full, 1);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      xfer_stb = ($urandom % 4) == 0;
      xfer_data = {$urandom, $urandom, $urandom};
      slot_idx = 5'($urandom % 32);
      fs_seen = $urandom % 2;
      sr_rd = ($urandom % 6) == 0;
      dr_rd = 4'($urandom & $urandom);
      ie_data = $urandom % 2; ie_exc = $urandom % 2; ie_even = $urandom % 2;
      if ((c % 97) == 0) rx_en = (($urandom % 8) == 0) ? 4'h0 : 4'($urandom);
      if ((c % 211) == 0) net_mode = $urandom % 2;
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule